// File: doc/BRIEF.md
# Retention-Aware Row Refresh Scheduler

This block sits on the memory-controller side of a DRAM channel. It decides which rows to refresh each time a refresh period begins. Rows are sorted by how long they hold their data. Rows with weak cells are refreshed every base period, which is 64 ms in a typical device. A second group is refreshed every other period, and all remaining rows every fourth period. Because false positives are tolerated, group membership is kept in two small Bloom filters instead of a per-row table.

Before refreshing starts, software programs the filters. It raises a programming enable, presents a row address and pulses an insert strobe for the fast or the medium group. A clear strobe empties both filters, which sends every row back to the slowest group. Each period tick starts one sweep over all rows in ascending order. For every row that is due in the current period, the block offers a refresh request on a valid/ready handshake. The request carries the row address and its group code.

Top module: `retention_refresh_sched`

## Requirements
- R1: After reset `reqValid` is 0, both filters are empty and the period counter is 0, so the first sweep requests every row with group code 2.
- R2: Each accepted `refreshTick` starts one sweep that visits the rows from address 0 up to the highest address. The sweep issues requests only for due rows, in strictly ascending address order, and issues nothing once the sweep has ended.
- R3: A row is a member of a filter only when both of its two hashed bits are set. Hash k is computed in two steps. First, the row address is rotated left by ROT_k bits within ROW_W bits. Second, rotated bit i is XORed into index bit (i mod FILT_LOG2).
- R4: A row in the fast filter is requested in every sweep with group code 0, even if it is also in the medium filter.
- R5: A row in the medium filter but not the fast filter is requested with group code 1, only in sweeps whose period count has bit 0 equal to 0.
- R6: A row in neither filter is requested with group code 2, only in sweeps whose period count has bits 1:0 equal to 00.
- R7: While `reqValid` is 1 and `reqReady` is 0, `reqValid`, `reqRow` and `reqBin` stay unchanged on the next cycle.
- R8: A `progClear` pulse while `progEnable` is 1 empties both filters.
- R9: While `progEnable` is 1, no new request is raised and scanning is frozen. Insert and clear strobes are ignored when `progEnable` is 0.
- R10: A tick that arrives during a sweep, or while programming holds the block idle, is remembered (one deep). The next sweep starts once the current one ends. The period counter advances by one at the end of every sweep.
- R11: `reqBin` takes only the codes 0 (base period), 1 (twice the base) and 2 (four times the base), never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refreshTick | input | 1 | One-cycle pulse marking the start of a base refresh period |
| progEnable | input | 1 | Programming in progress; freezes refresh issue |
| progRow | input | ROW_W | Row address to insert |
| progInsertBase | input | 1 | Insert strobe for the base-period filter |
| progInsertDouble | input | 1 | Insert strobe for the double-period filter |
| progClear | input | 1 | Empty both filters |
| reqValid | output | 1 | Refresh request offered |
| reqReady | input | 1 | Request accepted when high with reqValid |
| reqRow | output | ROW_W | Row to refresh |
| reqBin | output | 2 | Group code of the requested row |

## Verification
The bench runs a small configuration with 64 rows and 16-bit filters. In that configuration hash collisions are frequent, so false-positive members show up in the expected lists. An arithmetic model of the filters and the period rules predicts the full request list for each sweep.

Sweeps are run with three filter contents: empty, programmed, and cleared. They cover period counts 0 through 8, so periods that select all rows, only the fast rows, and fast plus medium rows can be told apart. The ready input is driven always high, alternating and pseudo-random, which separates handshake stalls from scan order. Further runs cover three cases that the plain sweeps do not reach:
- a programming hold in the middle of a sweep;
- a second tick during a sweep;
- an insert attempted with programming disabled.

// File: rtl/rr_sched_pkg.sv
package rr_sched_pkg;

  // Group code carried with every request
  typedef enum logic [1:0] {
    BIN_BASE   = 2'd0,
    BIN_DOUBLE = 2'd1,
    BIN_QUAD   = 2'd2
  } binClassE;

  // Strobes from control to the filter datapath
  typedef struct packed {
    logic clearAll;
    logic insertBase;
    logic insertDouble;
  } filtStrobeS;

endpackage

// File: rtl/rr_filter_bank.sv
module rr_filter_bank
  import rr_sched_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int FILT_LOG2 = 10,
  parameter int ROT_A     = 0,
  parameter int ROT_B     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  filtStrobeS       strobe,
  input  logic [ROW_W-1:0] progRow,
  input  logic [ROW_W-1:0] queryRow,
  output logic             hitBase,
  output logic             hitDouble
);

  localparam int FBITS    = 1 << FILT_LOG2;
  localparam int NUM_FILT = 2;
  localparam int ROW_IW   = (ROW_W > 1) ? $clog2(ROW_W) : 1;
  localparam int FLT_IW   = (FILT_LOG2 > 1) ? $clog2(FILT_LOG2) : 1;

  // Rotate left by rot inside ROW_W bits, then XOR-fold into FILT_LOG2 bits
  function automatic logic [FILT_LOG2-1:0] foldIdx(input logic [ROW_W-1:0] r, input int rot);
    logic [ROW_W-1:0]     rr;
    logic [FILT_LOG2-1:0] acc;
    rr  = '0;
    acc = '0;
    for (int i = 0; i < ROW_W; i++) rr[ROW_IW'((i + rot) % ROW_W)] = r[i];
    for (int i = 0; i < ROW_W; i++) acc[FLT_IW'(i % FILT_LOG2)] ^= rr[i];
    return acc;
  endfunction

  logic [FILT_LOG2-1:0] insIdxA, insIdxB, qryIdxA, qryIdxB;
  logic [NUM_FILT-1:0]  hitVec;

  assign insIdxA = foldIdx(progRow, ROT_A);
  assign insIdxB = foldIdx(progRow, ROT_B);
  assign qryIdxA = foldIdx(queryRow, ROT_A);
  assign qryIdxB = foldIdx(queryRow, ROT_B);

  for (genvar g = 0; g < NUM_FILT; g++) begin : gFilt
    logic [FBITS-1:0] bitVec;
    logic             insSel;
    assign insSel = (g == 0) ? strobe.insertBase : strobe.insertDouble;

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearAll) begin
        bitVec <= '0;
      end else if (insSel) begin
        bitVec[insIdxA] <= 1'b1;
        bitVec[insIdxB] <= 1'b1;
      end
    end

    assign hitVec[g] = bitVec[qryIdxA] & bitVec[qryIdxB];
  end

  assign hitBase   = hitVec[0];
  assign hitDouble = hitVec[1];

endmodule

// File: rtl/rr_scan_ctrl.sv
module rr_scan_ctrl
  import rr_sched_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refreshTick,
  input  logic             progEnable,
  input  logic             progInsertBase,
  input  logic             progInsertDouble,
  input  logic             progClear,
  input  logic             hitBase,
  input  logic             hitDouble,
  input  logic             reqReady,
  output filtStrobeS       strobe,
  output logic [ROW_W-1:0] scanRow,
  output logic             reqValid,
  output logic [ROW_W-1:0] reqRow,
  output logic [1:0]       reqBin,
  output logic [1:0]       epochNow
);

  localparam int EPOCH_W = 2;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_ISSUE} stateE;

  stateE              state;
  logic               tickPend;
  logic [EPOCH_W-1:0] epoch;
  binClassE           binReg;
  binClassE           rowClass;
  logic               rowDue;
  logic               lastRow;
  logic               startSweep;

  // Programming strobes only pass while programming is enabled
  assign strobe.clearAll     = progEnable & progClear;
  assign strobe.insertBase   = progEnable & progInsertBase;
  assign strobe.insertDouble = progEnable & progInsertDouble;

  // Shortest period wins: base filter checked first
  always_comb begin
    if (hitBase) begin
      rowClass = BIN_BASE;
      rowDue   = 1'b1;
    end else if (hitDouble) begin
      rowClass = BIN_DOUBLE;
      rowDue   = ~epoch[0];
    end else begin
      rowClass = BIN_QUAD;
      rowDue   = (epoch == '0);
    end
  end

  assign lastRow    = &scanRow;
  assign startSweep = (state == S_IDLE) && (tickPend || refreshTick) && !progEnable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tickPend <= 1'b0;
      epoch    <= '0;
      scanRow  <= '0;
      reqValid <= 1'b0;
      reqRow   <= '0;
      binReg   <= BIN_BASE;
    end else begin
      tickPend <= startSweep ? (tickPend && refreshTick) : (tickPend || refreshTick);
      case (state)
        S_IDLE: begin
          if (startSweep) begin
            state   <= S_SCAN;
            scanRow <= '0;
          end
        end
        S_SCAN: begin
          if (!progEnable) begin
            if (rowDue) begin
              reqValid <= 1'b1;
              reqRow   <= scanRow;
              binReg   <= rowClass;
              state    <= S_ISSUE;
            end else if (lastRow) begin
              epoch <= epoch + 1'b1;
              state <= S_IDLE;
            end else begin
              scanRow <= scanRow + 1'b1;
            end
          end
        end
        S_ISSUE: begin
          if (reqReady) begin
            reqValid <= 1'b0;
            if (lastRow) begin
              epoch <= epoch + 1'b1;
              state <= S_IDLE;
            end else begin
              scanRow <= scanRow + 1'b1;
              state   <= S_SCAN;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqBin   = binReg;
  assign epochNow = epoch;

endmodule

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched
  import rr_sched_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int FILT_LOG2 = 10,
  parameter int ROT_A     = 0,
  parameter int ROT_B     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refreshTick,
  input  logic             progEnable,
  input  logic [ROW_W-1:0] progRow,
  input  logic             progInsertBase,
  input  logic             progInsertDouble,
  input  logic             progClear,
  output logic             reqValid,
  input  logic             reqReady,
  output logic [ROW_W-1:0] reqRow,
  output logic [1:0]       reqBin
);

  filtStrobeS       strobe;
  logic [ROW_W-1:0] scanRow;
  logic             hitBase, hitDouble;
  logic [1:0]       epochNow;

  rr_scan_ctrl #(.ROW_W(ROW_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .refreshTick(refreshTick), .progEnable(progEnable),
    .progInsertBase(progInsertBase), .progInsertDouble(progInsertDouble),
    .progClear(progClear), .hitBase(hitBase), .hitDouble(hitDouble),
    .reqReady(reqReady), .strobe(strobe), .scanRow(scanRow),
    .reqValid(reqValid), .reqRow(reqRow), .reqBin(reqBin), .epochNow(epochNow)
  );

  rr_filter_bank #(.ROW_W(ROW_W), .FILT_LOG2(FILT_LOG2), .ROT_A(ROT_A), .ROT_B(ROT_B)) filt_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .progRow(progRow),
    .queryRow(scanRow), .hitBase(hitBase), .hitDouble(hitDouble)
  );

endmodule

// File: rtl/rr_sched_checker.sv
module rr_sched_checker #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             progEnable,
  input logic             reqValid,
  input logic             reqReady,
  input logic [ROW_W-1:0] reqRow,
  input logic [1:0]       reqBin,
  input logic [1:0]       epochNow
);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqRow) && $stable(reqBin));

  assert_no_issue_in_prog_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> !$past(progEnable));

  assert_bin_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqBin != 2'd3);

  assert_double_epoch_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqBin == 2'd1 |-> !epochNow[0]);

  assert_quad_epoch_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqBin == 2'd2 |-> epochNow == 2'd0);

endmodule

bind retention_refresh_sched rr_sched_checker #(.ROW_W(ROW_W)) chk_i (
  .clk(clk), .rstN(rstN), .progEnable(progEnable), .reqValid(reqValid),
  .reqReady(reqReady), .reqRow(reqRow), .reqBin(reqBin), .epochNow(epochNow)
);

// File: tb/retention_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module retention_refresh_sched_tb_top;

  localparam int ROW_W = 6;
  localparam int FL    = 4;
  localparam int RA    = 0;
  localparam int RB    = 2;
  localparam int NROWS = 1 << ROW_W;

  logic clk = 0;
  logic rstN = 0;
  logic refreshTick = 0, progEnable = 0, progInsertBase = 0, progInsertDouble = 0, progClear = 0;
  logic [ROW_W-1:0] progRow = '0;
  logic reqValid, reqReady;
  logic [ROW_W-1:0] reqRow;
  logic [1:0] reqBin;

  always #2.5 clk = ~clk;

  retention_refresh_sched #(.ROW_W(ROW_W), .FILT_LOG2(FL), .ROT_A(RA), .ROT_B(RB)) dut_i (
    .clk(clk), .rstN(rstN), .refreshTick(refreshTick), .progEnable(progEnable),
    .progRow(progRow), .progInsertBase(progInsertBase), .progInsertDouble(progInsertDouble),
    .progClear(progClear), .reqValid(reqValid), .reqReady(reqReady),
    .reqRow(reqRow), .reqBin(reqBin)
  );

  int nChecks = 0, nFails = 0, benchEpoch = 0;
  int baseMask = 0, dblMask = 0;
  bit done = 0;
  int expRow[512];
  int expBin[512];
  bit [15:0] lfsr = 16'hACE1;

  initial reqReady = 1'b1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R3 model: rotate left, fold by FL-bit chunks
  function automatic int hashOf(input int row, input int rot);
    int rotd, idx;
    rotd = (rot == 0) ? row : (((row << rot) | (row >> (ROW_W - rot))) & (NROWS - 1));
    idx = 0;
    for (int k = 0; k * FL < ROW_W; k++) idx ^= (rotd >> (k * FL)) & ((1 << FL) - 1);
    return idx;
  endfunction

  function automatic bit inMask(input int mask, input int row);
    return ((mask >> hashOf(row, RA)) & 1) == 1 && ((mask >> hashOf(row, RB)) & 1) == 1;
  endfunction

  task automatic insertRow(input int row, input bit toBase);
    @(negedge clk);
    progRow = ROW_W'(row);
    progInsertBase = toBase;
    progInsertDouble = !toBase;
    if (progEnable) begin
      if (toBase) baseMask |= (1 << hashOf(row, RA)) | (1 << hashOf(row, RB));
      else        dblMask  |= (1 << hashOf(row, RA)) | (1 << hashOf(row, RB));
    end
    @(negedge clk);
    progInsertBase = 0;
    progInsertDouble = 0;
  endtask

  // Runs nSweeps sweeps; nTicks pulses fired inside (0,1,2); readyMode 0 always,1 alternate,2 pseudo-random
  task automatic runSweeps(input int nSweeps, input int nTicks, input int readyMode, input bit holdMid);
    int cnt = 0, idx = 0, c = 0;
    bit pV = 0, pR = 0, pP = 0;
    int pRow = 0, pBin = 0, extra = 0;
    for (int s = 0; s < nSweeps; s++) begin
      int e = (benchEpoch + s) % 4;
      for (int r = 0; r < NROWS; r++) begin
        if (inMask(baseMask, r)) begin expRow[cnt] = r; expBin[cnt] = 0; cnt++; end
        else if (inMask(dblMask, r)) begin
          if (e % 2 == 0) begin expRow[cnt] = r; expBin[cnt] = 1; cnt++; end
        end else if (e == 0) begin expRow[cnt] = r; expBin[cnt] = 2; cnt++; end
      end
    end
    while ((idx < cnt || c < 4) && c < 4000) begin
      @(negedge clk);
      refreshTick = (nTicks >= 1 && c == 0) || (nTicks >= 2 && c == 3);
      progEnable = holdMid && c >= 6 && c < 16;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reqReady = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? c[0] : lfsr[0];
      #0.1;
      if (pV && !pR)
        check(reqValid && int'(reqRow) == pRow && int'(reqBin) == pBin, "R7", "stalled request changed, row",
              int'(reqRow), pRow);
      if (reqValid && !pV && pP)
        check(0, "R9", "request raised during programming, row", int'(reqRow), -1);
      if (reqValid && reqReady) begin
        if (idx < cnt) begin
          check(int'(reqRow) == expRow[idx], "R2", "request row", int'(reqRow), expRow[idx]);
          check(int'(reqBin) == expBin[idx], "R4/R5/R6/R11 bin", "request bin", int'(reqBin), expBin[idx]);
          idx++;
        end else begin
          check(0, "R2", "unexpected request row", int'(reqRow), -1);
        end
      end
      pV = reqValid; pR = reqReady; pP = progEnable;
      pRow = int'(reqRow); pBin = int'(reqBin);
      c++;
    end
    check(idx == cnt, "R2", "requests received in sweep", idx, cnt);
    refreshTick = 0; progEnable = 0; reqReady = 1;
    for (int t = 0; t < 90; t++) begin
      @(negedge clk);
      if (reqValid) extra++;
    end
    check(extra == 0, "R2", "requests after sweep end", extra, 0);
    benchEpoch += nSweeps;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!reqValid, "R1", "reqValid after reset", int'(reqValid), 0);
    end
    // R1/R6: empty filters, period 0 -> every row with code 2
    runSweeps(1, 1, 0, 0);
    // R9: insert with programming disabled must be ignored
    insertRow(20, 1);
    // Programming with a tick held off (R9, R10)
    @(negedge clk); progEnable = 1;
    @(negedge clk); refreshTick = 1;
    @(negedge clk); refreshTick = 0;
    insertRow(5, 1);
    insertRow(40, 1);
    insertRow(12, 0);
    insertRow(33, 0);
    insertRow(60, 0);
    insertRow(5, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!reqValid, "R9", "reqValid while programming", int'(reqValid), 0);
    end
    @(negedge clk); progEnable = 0;
    // Period 1: remembered tick runs (R10); base rows only (R3, R4)
    runSweeps(1, 0, 0, 0);
    // Period 2: base and double rows, alternating ready (R5, R7)
    runSweeps(1, 1, 1, 0);
    // Period 3: mid-sweep programming hold, random ready (R9, R7)
    runSweeps(1, 1, 2, 1);
    // Period 4: all three groups (R6)
    runSweeps(1, 1, 2, 0);
    // Periods 5 and 6: second tick during a sweep (R10)
    runSweeps(2, 2, 0, 0);
    // R8: clear, then period 7 has nothing due, period 8 all rows code 2
    @(negedge clk); progEnable = 1;
    @(negedge clk); progClear = 1;
    baseMask = 0; dblMask = 0;
    @(negedge clk); progClear = 0; progEnable = 0;
    runSweeps(1, 1, 0, 0);
    runSweeps(1, 1, 1, 0);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule